// File: doc/BRIEF.md
# Boot-Stage Triggered Reset Pulse Sequencer

This block follows the 8-bit progress code that a target processor reports while it boots. It steps through one fixed sequence for each boot attempt. An arming code makes it raise a clock slowdown request. When the target enters its hash-compare stage, a programmable delay counter starts. When that delay runs out, the block drives a very short reset pulse. After a fixed hold time it drops the slowdown request. It then watches the next accepted code to decide the outcome. A failure code sets a fail flag. Any other code sets a done flag. In either case the block goes back to idle for the next attempt.

There are two variants, and the mode input selects one of them when the block arms. Each variant has its own code values, its own pulse width and its own delay resolution. In the fine variant the delay counter advances two ticks per clock cycle, so a tick is half a clock period. The progress code is an asynchronous bus. It passes through a synchronizer and a stability filter before the sequencer acts on it.

Top module: `bootseq_pulse_top`

## Requirements
- R1: While reset is high and in the first cycle after it, slow_req_o, rst_pulse_o, done_o and fail_o are all 0.
- R2: A code value takes effect only after two synchronizer flops and two consecutive equal samples. A value held for one clock cycle has no effect. A stable arming code applied before clock edge k raises slow_req_o after edge k+4.
- R3: From idle, only the arming code raises slow_req_o. The arming code is 0x36 when mode_i=0 (coarse variant) and 0xD8 when mode_i=1 (fine variant). Every other code, including a failure code, leaves the block idle.
- R4: After the block has armed, entry into the compare code starts the delay counter and samples delay_i. The compare code is 0x39 for the coarse variant and 0xDA for the fine one. Let that acceptance be edge E. The counter adds 1 tick per cycle (coarse) or 2 ticks per cycle (fine), and rst_pulse_o rises after edge E+1+ceil(delay/step).
- R5: The reset pulse lasts 5 ticks in the coarse variant, which is 5 cycles. It lasts 2 ticks in the fine variant, which is 1 cycle.
- R6: slow_req_o falls HOLD_CYCLES cycles after rst_pulse_o falls.
- R7: Once the block has armed, the failure code ends the attempt at once. The failure code is 0xAD (coarse) or 0xF2 (fine). slow_req_o and rst_pulse_o drop, fail_o rises, and if the pulse has not yet been sent it is never sent.
- R8: After the slowdown is released, the next accepted code decides the outcome. The failure code raises fail_o. Any other code raises done_o. Either way the block returns to idle.
- R9: done_o and fail_o stay set until the next arming, and they clear in the same cycle that slow_req_o rises.
- R10: The variant is latched when the block arms. Changing mode_i later in the attempt does not change the codes, the tick step or the pulse width of that attempt.
- R11: At most one reset pulse is sent per attempt, and rst_pulse_o is high only while slow_req_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | CODE_W | Asynchronous boot progress code from the target |
| delay_i | input | DELAY_W | Pulse delay in ticks, sampled when the compare code is entered |
| mode_i | input | 1 | Variant select: 0 coarse, 1 fine; latched when the block arms |
| slow_req_o | output | 1 | Level request to slow the target clock |
| rst_pulse_o | output | 1 | Short reset pulse to the target |
| done_o | output | 1 | Attempt passed the compare stage without the failure code |
| fail_o | output | 1 | Failure code seen during or after the attempt |

## Verification
Some properties are checked by the assertions on every cycle. The pulse may only appear under an active slowdown, and only once per attempt. Its length must match the latched variant unless an abort cuts it short. The slowdown must be released exactly HOLD_CYCLES after the pulse on the normal path. Each outcome flag must rise only when both outputs are low. Other behaviour only the bench scenarios can show. These cover the end-to-end cycle of every edge from a code change to a pin, the one-cycle glitch rejection, the tick step of each variant with zero and odd delays, aborts both before and during counting, the clearing of the flags at the next arming, and a mode change part way through an attempt.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  // Sequencer phases of one boot attempt.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_COUNT = 3'd2,
    ST_PULSE = 3'd3,
    ST_HOLD  = 3'd4,
    ST_WATCH = 3'd5
  } seq_state_t;

  // Ceiling division, used for tick-to-cycle conversions.
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/bootseq_code_filter.sv
module bootseq_code_filter #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              code_new
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [CODE_W-1:0] sync_q [SYNC_STAGES];
  logic [CODE_W-1:0] prev_q;

  // Synchronizer chain.
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= '0;
          else     sync_q[g] <= code_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= '0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  // Stability filter: accept a value seen on two consecutive samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      code_q   <= '0;
      code_new <= 1'b0;
    end else begin
      prev_q   <= sync_q[LAST];
      code_new <= 1'b0;
      if ((sync_q[LAST] == prev_q) && (sync_q[LAST] != code_q)) begin
        code_q   <= sync_q[LAST];
        code_new <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bootseq_tick_counter.sv
module bootseq_tick_counter #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [1:0]         step,
  input  logic [LIMIT_W-1:0] limit,
  output logic               reached
);

  localparam int CNT_W = LIMIT_W + 1;

  logic [CNT_W-1:0] cnt_q;

  // Held at zero outside its phase; stops once the limit is met.
  assign reached = (cnt_q >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt_q <= '0;
    else if (!reached) cnt_q <= cnt_q + CNT_W'(step);
  end

endmodule

// File: rtl/bootseq_pulse_top.sv
module bootseq_pulse_top #(
  parameter int              CODE_W        = 8,
  parameter int              DELAY_W       = 16,
  parameter int              HOLD_CYCLES   = 16,
  parameter int              SYNC_STAGES   = 2,
  parameter int              STEP_A        = 1,
  parameter int              STEP_B        = 2,
  parameter int              PULSE_TICKS_A = 5,
  parameter int              PULSE_TICKS_B = 2,
  parameter logic [CODE_W-1:0] ARM_A  = 8'h36,
  parameter logic [CODE_W-1:0] CMP_A  = 8'h39,
  parameter logic [CODE_W-1:0] FAIL_A = 8'hAD,
  parameter logic [CODE_W-1:0] ARM_B  = 8'hD8,
  parameter logic [CODE_W-1:0] CMP_B  = 8'hDA,
  parameter logic [CODE_W-1:0] FAIL_B = 8'hF2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic               mode_i,
  output logic               slow_req_o,
  output logic               rst_pulse_o,
  output logic               done_o,
  output logic               fail_o
);
  import bootseq_pkg::*;

  // Pulse limit in ticks is width minus one step (see counter rule).
  localparam int PW_LIM_A_I = PULSE_TICKS_A - STEP_A;
  localparam int PW_LIM_B_I = PULSE_TICKS_B - STEP_B;
  localparam int PW_MAX     = (PW_LIM_A_I > PW_LIM_B_I) ? PW_LIM_A_I : PW_LIM_B_I;
  localparam int PW_W       = $clog2(PW_MAX + 1) + 1;
  localparam int HOLD_W     = $clog2(HOLD_CYCLES + 1) + 1;
  localparam logic [PW_W-1:0]   PW_LIM_A = PW_W'(PW_LIM_A_I);
  localparam logic [PW_W-1:0]   PW_LIM_B = PW_W'(PW_LIM_B_I);
  localparam logic [HOLD_W-1:0] HOLD_LIM = HOLD_W'(HOLD_CYCLES - 1);
  localparam logic [1:0]        STEP_A_V = 2'(STEP_A);
  localparam logic [1:0]        STEP_B_V = 2'(STEP_B);

  seq_state_t          state_q;
  logic                mode_q;
  logic [DELAY_W-1:0]  delay_q;
  logic [CODE_W-1:0]   code_q;
  logic                code_new;
  logic                slow_q, pulse_q, done_q, fail_q;

  logic [CODE_W-1:0]   arm_code, cmp_code, fail_code;
  logic [1:0]          step_now;
  logic [PW_W-1:0]     pw_limit;
  logic                dly_hit, pw_hit, hold_hit;
  logic                saw_fail, saw_cmp;

  bootseq_code_filter #(
    .CODE_W      (CODE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) filt_i (
    .clk      (clk),
    .rst      (rst),
    .code_in  (code_i),
    .code_q   (code_q),
    .code_new (code_new)
  );

  // Variant selection: arming looks at the live mode, the rest at the latched one.
  always_comb begin
    arm_code  = mode_i ? ARM_B  : ARM_A;
    cmp_code  = mode_q ? CMP_B  : CMP_A;
    fail_code = mode_q ? FAIL_B : FAIL_A;
    step_now  = mode_q ? STEP_B_V : STEP_A_V;
    pw_limit  = mode_q ? PW_LIM_B : PW_LIM_A;
  end

  assign saw_fail = code_new && (code_q == fail_code);
  assign saw_cmp  = code_new && (code_q == cmp_code);

  bootseq_tick_counter #(.LIMIT_W(DELAY_W)) dly_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_COUNT),
    .step    (step_now),
    .limit   (delay_q),
    .reached (dly_hit)
  );

  bootseq_tick_counter #(.LIMIT_W(PW_W)) pw_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_PULSE),
    .step    (step_now),
    .limit   (pw_limit),
    .reached (pw_hit)
  );

  bootseq_tick_counter #(.LIMIT_W(HOLD_W)) hold_cnt_i (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_HOLD),
    .step    (2'd1),
    .limit   (HOLD_LIM),
    .reached (hold_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      delay_q <= '0;
      slow_q  <= 1'b0;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (code_new && (code_q == arm_code)) begin
            state_q <= ST_ARMED;
            mode_q  <= mode_i;
            slow_q  <= 1'b1;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
          end
        end
        ST_WATCH: begin
          if (code_new) begin
            state_q <= ST_IDLE;
            if (code_q == fail_code) fail_q <= 1'b1;
            else                     done_q <= 1'b1;
          end
        end
        default: begin
          if (saw_fail) begin
            state_q <= ST_IDLE;
            slow_q  <= 1'b0;
            pulse_q <= 1'b0;
            fail_q  <= 1'b1;
          end else begin
            case (state_q)
              ST_ARMED: if (saw_cmp) begin
                state_q <= ST_COUNT;
                delay_q <= delay_i;
              end
              ST_COUNT: if (dly_hit) begin
                state_q <= ST_PULSE;
                pulse_q <= 1'b1;
              end
              ST_PULSE: if (pw_hit) begin
                state_q <= ST_HOLD;
                pulse_q <= 1'b0;
              end
              ST_HOLD: if (hold_hit) begin
                state_q <= ST_WATCH;
                slow_q  <= 1'b0;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  assign slow_req_o  = slow_q;
  assign rst_pulse_o = pulse_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;

endmodule

// File: rtl/bootseq_pulse_checker.sv
module bootseq_pulse_checker #(
  parameter int HOLD_CYCLES   = 16,
  parameter int STEP_A        = 1,
  parameter int STEP_B        = 2,
  parameter int PULSE_TICKS_A = 5,
  parameter int PULSE_TICKS_B = 2
) (
  input logic clk,
  input logic rst,
  input logic slow,
  input logic pulse,
  input logic done,
  input logic fail,
  input logic mode_b
);

  localparam int WID_A = (PULSE_TICKS_A + STEP_A - 1) / STEP_A;
  localparam int WID_B = (PULSE_TICKS_B + STEP_B - 1) / STEP_B;
  localparam logic [15:0] CMAX = 16'hFFFF;

  logic [15:0] width_cnt, since_pulse;
  logic        prev_pulse, pulsed_this_try;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_cnt       <= '0;
      since_pulse     <= '0;
      prev_pulse      <= 1'b0;
      pulsed_this_try <= 1'b0;
    end else begin
      prev_pulse <= pulse;
      if (pulse) width_cnt <= (width_cnt == CMAX) ? CMAX : width_cnt + 16'd1;
      else       width_cnt <= '0;
      if (prev_pulse && !pulse)                       since_pulse <= 16'd1;
      else if (since_pulse != 0 && since_pulse != CMAX) since_pulse <= since_pulse + 16'd1;
      if (!slow)       pulsed_this_try <= 1'b0;
      else if (pulse)  pulsed_this_try <= 1'b1;
    end
  end

  assert_pulse_under_slow_R11: assert property (@(posedge clk) disable iff (rst)
    pulse |-> slow);

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> !pulsed_this_try);

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse) && !fail) |-> (width_cnt == 16'(mode_b ? WID_B : WID_A)));

  assert_hold_time_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(slow) && !fail) |-> (since_pulse == 16'(HOLD_CYCLES)));

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (!slow && !pulse));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!slow && !pulse && !fail));

endmodule

bind bootseq_pulse_top bootseq_pulse_checker #(
  .HOLD_CYCLES   (HOLD_CYCLES),
  .STEP_A        (STEP_A),
  .STEP_B        (STEP_B),
  .PULSE_TICKS_A (PULSE_TICKS_A),
  .PULSE_TICKS_B (PULSE_TICKS_B)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .slow   (slow_req_o),
  .pulse  (rst_pulse_o),
  .done   (done_o),
  .fail   (fail_o),
  .mode_b (mode_q)
);

// File: tb/bootseq_pulse_top_tb_top.sv
module bootseq_pulse_top_tb_top;

  localparam int HOLD = 16;
  localparam int K_SR = 0, K_SF = 1, K_PR = 2, K_PF = 3;
  localparam int K_DR = 4, K_DF = 5, K_FR = 6, K_FF = 7;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  code;
  logic [15:0] dly;
  logic        mode;
  logic        slow, pulse, done, fail;

  always #4 clk = ~clk;

  bootseq_pulse_top #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .code_i      (code),
    .delay_i     (dly),
    .mode_i      (mode),
    .slow_req_o  (slow),
    .rst_pulse_o (pulse),
    .done_o      (done),
    .fail_o      (fail)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int    kind;
    int    at;
    string tag;
  } ev_t;
  ev_t exp_q[$];

  bit last_done = 1'b0;
  bit last_fail = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic push_ev(input int k, input int at, input string tag);
    ev_t e;
    e.kind = k; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic see(input int k);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R11", "unexpected output edge kind", k, -1);
    end else begin
      e = exp_q.pop_front();
      check(e.kind == k, e.tag, "edge kind", k, e.kind);
      check(e.at == cyc, e.tag, "edge cycle", cyc, e.at);
    end
  endtask

  // Monitor: compares each output edge against the scoreboard.
  bit   mon_on = 1'b0;
  logic ps = 1'b0, pp = 1'b0, pd = 1'b0, pf = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (slow  !== ps) see(slow  ? K_SR : K_SF);
      if (pulse !== pp) see(pulse ? K_PR : K_PF);
      if (done  !== pd) see(done  ? K_DR : K_DF);
      if (fail  !== pf) see(fail  ? K_FR : K_FF);
      ps = slow; pp = pulse; pd = done; pf = fail;
    end
  end

  task automatic drive(input logic [7:0] c, output int t);
    @(negedge clk);
    code = c;
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm_expect(input int t0);
    push_ev(K_SR, t0 + 5, "R3");
    if (last_done) push_ev(K_DF, t0 + 5, "R9");
    if (last_fail) push_ev(K_FF, t0 + 5, "R9");
    last_done = 1'b0;
    last_fail = 1'b0;
  endtask

  // One full attempt; good=1 ends with a progress code, else the failure code.
  task automatic attempt(input bit mb, input int d, input bit good,
                         input bit flip, input string ptag);
    int t0, t1, t2, st, w, e, pr, pfa, sf;
    logic [7:0] a, c, f;
    a  = mb ? 8'hD8 : 8'h36;
    c  = mb ? 8'hDA : 8'h39;
    f  = mb ? 8'hF2 : 8'hAD;
    st = mb ? 2 : 1;
    w  = mb ? 2 : 5;
    @(negedge clk);
    mode = mb;
    dly  = 16'(d);
    drive(a, t0);
    arm_expect(t0);
    idle(8);
    if (flip) mode = ~mb;
    drive(c, t1);
    e   = t1 + 5;
    pr  = e + 1 + (d + st - 1) / st;
    pfa = pr + (w + st - 1) / st;
    sf  = pfa + HOLD;
    push_ev(K_PR, pr, ptag);
    push_ev(K_PF, pfa, flip ? "R10" : "R5");
    push_ev(K_SF, sf, "R6");
    while (cyc < sf + 2) @(negedge clk);
    drive(good ? 8'h4C : f, t2);
    push_ev(good ? K_DR : K_FR, t2 + 5, good ? "R8" : "R8_fail");
    idle(8);
    last_done = good;
    last_fail = !good;
    mode = 1'b0;
  endtask

  // Failure code during counting (in_count=1) or while only armed.
  task automatic abort_try(input bit mb, input bit in_count);
    int t0, t1, t2;
    logic [7:0] a, c, f;
    a = mb ? 8'hD8 : 8'h36;
    c = mb ? 8'hDA : 8'h39;
    f = mb ? 8'hF2 : 8'hAD;
    @(negedge clk);
    mode = mb;
    dly  = 16'd300;
    drive(a, t0);
    arm_expect(t0);
    idle(8);
    if (in_count) begin
      drive(c, t1);
      idle(20);
    end
    drive(f, t2);
    push_ev(K_SF, t2 + 5, "R7");
    push_ev(K_FR, t2 + 5, "R7");
    idle(12);
    check(pulse == 1'b0, "R7", "pulse after abort", int'(pulse), 0);
    last_fail = 1'b1;
    mode = 1'b0;
  endtask

  task automatic main_seq();
    int tdummy;
    rst  = 1'b1;
    code = 8'h00;
    dly  = 16'd0;
    mode = 1'b0;
    idle(4);
    check({slow, pulse, done, fail} == 4'b0, "R1", "outputs in reset",
          int'({slow, pulse, done, fail}), 0);
    rst = 1'b0;
    idle(1);
    check({slow, pulse, done, fail} == 4'b0, "R1", "outputs after reset",
          int'({slow, pulse, done, fail}), 0);
    mon_on = 1'b1;

    // R2: one-cycle arming code is filtered out.
    @(negedge clk); code = 8'h36;
    @(negedge clk); code = 8'h00;
    idle(10);
    check(slow == 1'b0, "R2", "slow after glitch", int'(slow), 0);
    // R3: a stable non-arming code and a failure code leave the block idle.
    drive(8'h39, tdummy);
    idle(10);
    check(slow == 1'b0, "R3", "slow after compare code in idle", int'(slow), 0);
    drive(8'hAD, tdummy);
    idle(10);
    check(fail == 1'b0, "R3", "fail flag after failure code in idle", int'(fail), 0);

    attempt(1'b0, 10, 1'b1, 1'b0, "R4");
    attempt(1'b0, 0,  1'b0, 1'b0, "R4_zero");
    attempt(1'b1, 7,  1'b1, 1'b0, "R4_fine_odd");
    attempt(1'b1, 1,  1'b1, 1'b0, "R4_fine_one");
    abort_try(1'b0, 1'b1);
    abort_try(1'b1, 1'b0);
    attempt(1'b0, 3,  1'b1, 1'b1, "R10");

    idle(10);
    check(exp_q.size() == 0, "R11", "expected edges left over", exp_q.size(), 0);
    check(slow == 1'b0 && pulse == 1'b0, "R6", "outputs quiet at end",
          int'({slow, pulse}), 0);
  endtask

  initial begin
    fork
      begin : run_blk
        main_seq();
      end
      begin : dog_blk
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule